// File: doc/BRIEF.md
# Power-State Sequencer with Substrate-Switch Handshake

This block steers a processor core between three power states: running, dozing and deep standby. When the core is running, every clock and peripheral is on and the substrate switches tie the bias lines to the rails. When it dozes, only the distributed clock tree is gated. The clock generators and the peripherals keep running, so a wake event brings the tree back on the next cycle. In deep standby the clock generators and the peripherals are stopped, the substrate switches are opened, and a body-bias generator takes over the substrate.

The path back from deep standby is ordered. The switch controls travel through a long distributed network, so the sequencer waits for a feedback level confirming they have arrived before any clock restarts. The wait is bounded by a programmable limit. On the first expiry the block raises a fault flag and pulses the switches off and on again. On a second expiry it falls back to standby. A one-entry holder keeps any request that arrives mid-sequence and applies it once the sequence settles. `ready` is low for the whole of every sequence.

Top module: `pwr_mode_seq`

## Requirements
- R1: A synchronous active-low reset puts the block in the running state: tree, generator and peripheral enables high, `sw_on`=1, `sw_on_n`=0, bias generator off, `ready`=1, `fault`=0.
- R2: `req_mode` codes: 2'b00 run, 2'b01 doze, 2'b10 deep standby, 2'b11 reserved. A doze request while running clears only `clk_tree_en`, one cycle later.
- R3: In doze, a `wake` pulse or a run request sets `clk_tree_en` again one cycle later, and the switch and generator outputs do not change.
- R4: Entry to standby takes one step per cycle in this order: tree off, peripherals off, generators off, switches off, then bias generator on together with `ready`. From doze the same five steps are taken.
- R5: Exit from standby starts on `wake` or a run request and runs in this order: bias off; switches on; wait for `sw_fb`; generators on and held for LOCK_CYC+1 cycles; peripherals on; tree on; then `ready`. With `sw_fb` high throughout, `ready` returns on the (LOCK_CYC+6)th edge.
- R6: `ready` is high only in the run, doze and standby states and low on every cycle of a sequence.
- R7: A valid request that arrives during a sequence is held, and the latest one wins. It acts on the first edge after the sequence settles.
- R8: If `sw_fb` stays low for `fb_limit`+1 cycles in the switch-on step, `fault` is set and the switches go off for one cycle before the step is retried with a fresh limit. A second expiry turns the switches off and, a cycle later, re-enters standby. `fault` clears when the next exit starts.
- R9: The following have no effect on any output: the reserved code, a request for the current state, a doze request in standby, and `wake` while running or during a sequence.
- R10: In doze, a standby request and `wake` in the same cycle start standby entry, and the wake is dropped.
- R11: `sw_on_n` is always the complement of `sw_on`, and `bias_gen_en` is never high while `sw_on` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| wake | input | 1 | Wake event |
| sw_fb | input | 1 | Feedback: switch-on controls have propagated |
| fb_limit | input | TO_W | Feedback timeout limit in cycles |
| clk_tree_en | output | 1 | Distributed clock tree enable |
| clk_gen_en | output | 1 | Clock generator enable |
| periph_en | output | 1 | Peripheral enable |
| sw_on | output | 1 | N-side substrate switch control (1 = closed) |
| sw_on_n | output | 1 | P-side substrate switch control (0 = closed) |
| bias_gen_en | output | 1 | Body-bias generator enable |
| ready | output | 1 | No sequence in progress |
| fault | output | 1 | Feedback timeout seen |

## Verification
In doze, a wake event and a standby request can land on the same edge, and the standby request must win. The bench forces this collision directly. Random traffic also produces it, with wake and request strobes drawn independently. A cycle-level reference model in the bench defines the expected outcome, and it predicts that the tree stays off and that `ready` drops. A bound property checks the same outcome.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
// Shared types for the power-state sequencer: mode codes, sequencer states
// and the bundle of gating outputs. Assumes a 2-bit mode code on the port.
package pms_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_DOZE = 2'b01,
        MODE_DEEP = 2'b10,
        MODE_RSV  = 2'b11
    } mode_e;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_DOZE,
        ST_DEEP,
        EN_GATE,
        EN_PERI,
        EN_CGEN,
        EN_SWOFF,
        XB_BIAS,
        XB_SWON,
        XB_RETRY,
        XB_CGEN,
        XB_PERI,
        XB_TREE
    } state_e;

    typedef struct packed {
        logic tree;
        logic gen;
        logic peri;
        logic sw_n;
        logic sw_p_n;
        logic bias;
        logic ready;
    } gate_t;

    // True when no sequence is in progress.
    function automatic logic is_settled(state_e s);
        return (s == ST_RUN) || (s == ST_DOZE) || (s == ST_DEEP);
    endfunction

endpackage

// File: rtl/pms_wait_ctr.sv
`timescale 1ns/1ps
// Down-counter used for both the feedback timeout and the generator lock
// wait. Load has priority over decrement; the count stops at zero.
// Assumes the owner loads it on the edge that enters a waiting state.
module pms_wait_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Count register: load, decrement, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Expiry flag.
    always_comb zero = (cnt == '0);

endmodule

// File: rtl/pms_req_hold.sv
`timescale 1ns/1ps
// One-entry holder for mode requests. A request seen during a sequence is
// kept (latest wins) and offered once the sequencer settles; in a settled
// state the holder empties every cycle. Reserved codes are never captured.
module pms_req_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       settled,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    output logic       eff_vld,
    output logic [1:0] eff_mode
);
    import pms_pkg::*;

    logic       new_ok;
    logic       pend_vld;
    logic [1:0] pend_mode;

    // Qualify the incoming request.
    always_comb new_ok = req_valid && (req_mode != MODE_RSV);

    // Holder register: capture during sequences, drain when settled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_mode <= MODE_RUN;
        end else if (!settled && new_ok) begin
            pend_vld  <= 1'b1;
            pend_mode <= req_mode;
        end else if (settled) begin
            pend_vld  <= 1'b0;
        end
    end

    // Request offered to the sequencer: a fresh one beats a held one.
    always_comb begin
        eff_vld  = settled && (new_ok || pend_vld);
        eff_mode = new_ok ? req_mode : pend_mode;
    end

endmodule

// File: rtl/pms_gate_dec.sv
`timescale 1ns/1ps
// Decodes the sequencer state into the gating outputs. Every output is a
// pure function of state, so each step's effect shows on the edge that
// enters it. Assumes the state encoding of pms_pkg.
module pms_gate_dec (
    input  pms_pkg::state_e st,
    output pms_pkg::gate_t  g
);
    import pms_pkg::*;

    // State-to-output table, one row per step.
    always_comb begin
        g = '{tree: 1'b0, gen: 1'b0, peri: 1'b0, sw_n: 1'b0,
              sw_p_n: 1'b1, bias: 1'b0, ready: 1'b0};
        unique case (st)
            ST_RUN:   g = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
            ST_DOZE:  g = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
            ST_DEEP:  g = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
            EN_GATE:  g = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            EN_PERI:  g = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            EN_CGEN:  g = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            EN_SWOFF: g = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
            XB_BIAS:  g = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
            XB_SWON:  g = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            XB_RETRY: g = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
            XB_CGEN:  g = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            XB_PERI:  g = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            XB_TREE:  g = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            default:  ;
        endcase
    end

endmodule

// File: rtl/pms_seq_fsm.sv
`timescale 1ns/1ps
// Sequencer state machine: settled-state decisions, the standby entry and
// exit steps, the feedback timeout with a single retry, and the fault flag.
// Assumes sw_fb is already synchronous to clk.
module pms_seq_fsm #(
    parameter int TO_W     = 8,
    parameter int LOCK_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eff_vld,
    input  logic [1:0]       eff_mode,
    input  logic             wake,
    input  logic             sw_fb,
    input  logic [TO_W-1:0]  fb_limit,
    input  logic             cnt_zero,
    output pms_pkg::state_e  st,
    output logic             cnt_load,
    output logic [TO_W-1:0]  cnt_val,
    output logic             cnt_dec,
    output logic             fault
);
    import pms_pkg::*;

    localparam logic [TO_W-1:0] LOCK_V = TO_W'(LOCK_CYC);

    state_e nxt;
    logic   retried;
    logic   go_run;
    logic   go_deep;
    logic   go_doze;
    logic   fb_expire;

    // Decode the offered request.
    always_comb begin
        go_run  = eff_vld && (eff_mode == MODE_RUN);
        go_doze = eff_vld && (eff_mode == MODE_DOZE);
        go_deep = eff_vld && (eff_mode == MODE_DEEP);
    end

    // Feedback window closed without confirmation.
    always_comb fb_expire = (st == XB_SWON) && !sw_fb && cnt_zero;

    // Next state and counter control.
    always_comb begin
        nxt      = st;
        cnt_load = 1'b0;
        cnt_val  = fb_limit;
        cnt_dec  = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (go_doze)      nxt = ST_DOZE;
                else if (go_deep) nxt = EN_GATE;
            end
            ST_DOZE: begin
                if (go_deep)              nxt = EN_GATE;
                else if (go_run || wake)  nxt = ST_RUN;
            end
            ST_DEEP: begin
                if (go_run || wake) nxt = XB_BIAS;
            end
            EN_GATE:  nxt = EN_PERI;
            EN_PERI:  nxt = EN_CGEN;
            EN_CGEN:  nxt = EN_SWOFF;
            EN_SWOFF: nxt = ST_DEEP;
            XB_BIAS: begin
                nxt      = XB_SWON;
                cnt_load = 1'b1;
            end
            XB_SWON: begin
                if (sw_fb) begin
                    nxt      = XB_CGEN;
                    cnt_load = 1'b1;
                    cnt_val  = LOCK_V;
                end else if (cnt_zero) begin
                    nxt = retried ? EN_SWOFF : XB_RETRY;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            XB_RETRY: begin
                nxt      = XB_SWON;
                cnt_load = 1'b1;
            end
            XB_CGEN: begin
                if (cnt_zero) nxt = XB_PERI;
                else          cnt_dec = 1'b1;
            end
            XB_PERI:  nxt = XB_TREE;
            XB_TREE:  nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= nxt;
    end

    // Retry marker: one retry per exit attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)                retried <= 1'b0;
        else if (st == XB_BIAS)    retried <= 1'b0;
        else if (st == XB_RETRY)   retried <= 1'b1;
    end

    // Fault flag: set on any expiry, cleared when a new exit begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 fault <= 1'b0;
        else if ((st == ST_DEEP) && (nxt == XB_BIAS)) fault <= 1'b0;
        else if (fb_expire)                         fault <= 1'b1;
    end

endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
// Top of the power-state sequencer. Ties the request holder, the state
// machine, the shared wait counter and the output decoder together.
// Assumes all inputs are synchronous to clk.
module pwr_mode_seq #(
    parameter int TO_W     = 8,
    parameter int LOCK_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_mode,
    input  logic            wake,
    input  logic            sw_fb,
    input  logic [TO_W-1:0] fb_limit,
    output logic            clk_tree_en,
    output logic            clk_gen_en,
    output logic            periph_en,
    output logic            sw_on,
    output logic            sw_on_n,
    output logic            bias_gen_en,
    output logic            ready,
    output logic            fault
);
    import pms_pkg::*;

    state_e          st;
    gate_t           g;
    logic            settled;
    logic            eff_vld;
    logic [1:0]      eff_mode;
    logic            cnt_load;
    logic [TO_W-1:0] cnt_val;
    logic            cnt_dec;
    logic            cnt_zero;

    // Settled-state flag for the holder.
    always_comb settled = is_settled(st);

    pms_req_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .settled  (settled),
        .req_valid(req_valid),
        .req_mode (req_mode),
        .eff_vld  (eff_vld),
        .eff_mode (eff_mode)
    );

    pms_seq_fsm #(.TO_W(TO_W), .LOCK_CYC(LOCK_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .eff_vld  (eff_vld),
        .eff_mode (eff_mode),
        .wake     (wake),
        .sw_fb    (sw_fb),
        .fb_limit (fb_limit),
        .cnt_zero (cnt_zero),
        .st       (st),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .cnt_dec  (cnt_dec),
        .fault    (fault)
    );

    pms_wait_ctr #(.W(TO_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .zero    (cnt_zero)
    );

    pms_gate_dec u_dec (
        .st(st),
        .g (g)
    );

    // Drive the ports from the decoded bundle.
    always_comb begin
        clk_tree_en = g.tree;
        clk_gen_en  = g.gen;
        periph_en   = g.peri;
        sw_on       = g.sw_n;
        sw_on_n     = g.sw_p_n;
        bias_gen_en = g.bias;
        ready       = g.ready;
    end

endmodule

// File: rtl/pms_checker.sv
`timescale 1ns/1ps
// Property checker for pwr_mode_seq, attached by bind. Observes ports only.
module pms_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_mode,
    input logic       wake,
    input logic       sw_fb,
    input logic       clk_tree_en,
    input logic       clk_gen_en,
    input logic       periph_en,
    input logic       sw_on,
    input logic       sw_on_n,
    input logic       bias_gen_en,
    input logic       ready,
    input logic       fault
);
    logic doze_now;

    // Doze is the only settled state with tree off and generators on.
    always_comb doze_now = ready && !clk_tree_en && clk_gen_en;

    assert_sw_complement_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_on_n == !sw_on);

    assert_bias_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bias_gen_en |-> !sw_on);

    assert_tree_needs_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_tree_en |-> (clk_gen_en && periph_en));

    assert_gen_stop_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gen_en) |-> $past(!periph_en));

    assert_bias_after_swoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bias_gen_en) |-> $past(!sw_on));

    assert_swon_after_bias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_on) |-> $past(!bias_gen_en));

    assert_gen_after_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gen_en) |-> $past(sw_fb));

    assert_fault_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> !sw_on);

    assert_doze_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (doze_now && wake && !req_valid) |=> (clk_tree_en && sw_on && ready));

    assert_doze_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (doze_now && wake && req_valid && (req_mode == 2'b10)) |=> (!clk_tree_en && !ready));

endmodule

bind pwr_mode_seq pms_checker u_pms_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .wake       (wake),
    .sw_fb      (sw_fb),
    .clk_tree_en(clk_tree_en),
    .clk_gen_en (clk_gen_en),
    .periph_en  (periph_en),
    .sw_on      (sw_on),
    .sw_on_n    (sw_on_n),
    .bias_gen_en(bias_gen_en),
    .ready      (ready),
    .fault      (fault)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
    localparam int TO_W = 8;
    localparam int LOCK = 4;
    // reference-model step codes
    localparam int M_RUN = 0, M_DOZE = 1, M_DEEP = 2, M_EG = 3, M_EP = 4, M_EC = 5,
                   M_ES = 6, M_XB = 7, M_XS = 8, M_XR = 9, M_XC = 10, M_XP = 11, M_XT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_mode = 2'b00;
    logic wake = 1'b0;
    logic sw_fb = 1'b0;
    logic [TO_W-1:0] fb_limit = 8'd3;
    logic clk_tree_en, clk_gen_en, periph_en, sw_on, sw_on_n, bias_gen_en, ready, fault;

    int vecs = 0;
    int fails = 0;
    string tag = "R1";

    int m_st, m_cnt;
    bit m_pv, m_retry, m_fault;
    bit [1:0] m_pm;

    always #4 clk = ~clk;

    pwr_mode_seq #(.TO_W(TO_W), .LOCK_CYC(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .wake(wake), .sw_fb(sw_fb), .fb_limit(fb_limit),
        .clk_tree_en(clk_tree_en), .clk_gen_en(clk_gen_en), .periph_en(periph_en),
        .sw_on(sw_on), .sw_on_n(sw_on_n), .bias_gen_en(bias_gen_en),
        .ready(ready), .fault(fault)
    );

    // Expected {tree,gen,peri,sw_on,sw_on_n,bias,ready,fault} per model step.
    function automatic bit [7:0] exp_vec(int s, bit f);
        bit [6:0] v;
        case (s)
            M_RUN:  v = 7'b1111001;
            M_DOZE: v = 7'b0111001;
            M_DEEP: v = 7'b0000111;
            M_EG:   v = 7'b0111000;
            M_EP:   v = 7'b0101000;
            M_EC:   v = 7'b0001000;
            M_XS:   v = 7'b0001000;
            M_XC:   v = 7'b0101000;
            M_XP:   v = 7'b0111000;
            M_XT:   v = 7'b1111000;
            default: v = 7'b0000100;
        endcase
        return {v, f};
    endfunction

    function automatic bit [7:0] got_vec();
        return {clk_tree_en, clk_gen_en, periph_en, sw_on, sw_on_n, bias_gen_en, ready, fault};
    endfunction

    task automatic model_reset();
        m_st = M_RUN; m_cnt = 0; m_pv = 0; m_pm = 0; m_retry = 0; m_fault = 0;
    endtask

    task automatic model_step(bit rv, bit [1:0] rm, bit wk, bit fb, int lim);
        bit settled = (m_st <= M_DEEP);
        bit newok = rv && (rm != 2'b11);
        bit ev = settled && (newok || m_pv);
        bit [1:0] em = newok ? rm : m_pm;
        int nst = m_st;
        case (m_st)
            M_RUN:  if (ev && em == 1) nst = M_DOZE; else if (ev && em == 2) nst = M_EG;
            M_DOZE: if (ev && em == 2) nst = M_EG; else if ((ev && em == 0) || wk) nst = M_RUN;
            M_DEEP: if ((ev && em == 0) || wk) begin nst = M_XB; m_fault = 0; end
            M_EG: nst = M_EP;
            M_EP: nst = M_EC;
            M_EC: nst = M_ES;
            M_ES: nst = M_DEEP;
            M_XB: begin nst = M_XS; m_cnt = lim; m_retry = 0; end
            M_XS: begin
                if (fb) begin nst = M_XC; m_cnt = LOCK; end
                else if (m_cnt == 0) begin m_fault = 1; nst = m_retry ? M_ES : M_XR; end
                else m_cnt--;
            end
            M_XR: begin nst = M_XS; m_cnt = lim; m_retry = 1; end
            M_XC: if (m_cnt == 0) nst = M_XP; else m_cnt--;
            M_XP: nst = M_XT;
            M_XT: nst = M_RUN;
            default: nst = M_RUN;
        endcase
        if (!settled && newok) begin m_pv = 1; m_pm = rm; end
        else if (settled) m_pv = 0;
        m_st = nst;
    endtask

    task automatic check_vec(string t, bit [7:0] exp);
        vecs++;
        if (got_vec() !== exp) begin
            fails++;
            $display("FAIL %s: outputs got %b expected %b", t, got_vec(), exp);
        end
    endtask

    // One cycle: drive at negedge, advance model, compare after the edge.
    task automatic cyc(bit rv, bit [1:0] rm, bit wk, bit fb);
        @(negedge clk);
        req_valid = rv; req_mode = rm; wake = wk; sw_fb = fb;
        model_step(rv, rm, wk, fb, int'(fb_limit));
        @(posedge clk);
        #1;
        check_vec(tag, exp_vec(m_st, m_fault));
        vecs++;
        if ((sw_on_n !== ~sw_on) || (bias_gen_en && sw_on)) begin
            fails++;
            $display("FAIL R11: sw_on=%b sw_on_n=%b bias=%b expected complement, no overlap",
                     sw_on, sw_on_n, bias_gen_en);
        end
    endtask

    task automatic idle(int n, bit fb);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 1'b0, fb);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin : main
        int unsigned seed_dummy;
        int edges;
        seed_dummy = $urandom(32'd7321);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        tag = "R1";
        check_vec("R1 reset state", 8'b1111_0010);

        tag = "R2"; cyc(1, 2'b01, 0, 0); idle(2, 0);
        tag = "R9"; cyc(1, 2'b01, 0, 0); cyc(1, 2'b11, 0, 0); idle(1, 0);
        tag = "R3"; cyc(0, 2'b00, 1, 0); idle(1, 0);
        tag = "R9"; cyc(0, 2'b00, 1, 0); cyc(1, 2'b00, 0, 0);
        tag = "R4"; cyc(1, 2'b10, 0, 0); idle(4, 0);
        check_vec("R4 standby reached", 8'b0000_1110);
        tag = "R9"; cyc(1, 2'b01, 0, 0); idle(2, 0);
        check_vec("R9 doze request ignored in standby", 8'b0000_1110);

        // R5 / R6: count edges from wake to ready with feedback present.
        tag = "R5"; cyc(0, 2'b00, 1, 1); edges = 1;
        while (!ready && edges < 40) begin
            if (ready !== 1'b0) break;
            cyc(0, 2'b00, 0, 1); edges++;
        end
        vecs++;
        if (edges != LOCK + 6) begin
            fails++;
            $display("FAIL R5/R6: ready returned after %0d edges expected %0d", edges, LOCK + 6);
        end

        // R7: run request during entry, doze request during exit.
        tag = "R7"; cyc(1, 2'b10, 0, 1); cyc(1, 2'b00, 0, 1); idle(4, 1);
        cyc(1, 2'b01, 0, 1); idle(LOCK + 8, 1);
        check_vec("R7 held doze applied", 8'b0111_0010);

        // R10: collide wake with standby request in doze.
        tag = "R10"; cyc(1, 2'b10, 1, 0); idle(5, 0);

        // R8: feedback never arrives, then a clean exit clears fault.
        tag = "R8"; fb_limit = 8'd2;
        cyc(0, 2'b00, 1, 0); idle(12, 0);
        check_vec("R8 fallback to standby with fault", 8'b0000_1111);
        cyc(0, 2'b00, 1, 1); idle(LOCK + 7, 1);
        check_vec("R8 fault cleared after clean exit", 8'b1111_0010);

        // Timeout with late feedback after retry.
        fb_limit = 8'd1; cyc(1, 2'b10, 0, 0); idle(4, 0);
        cyc(0, 2'b00, 1, 0); idle(4, 0); idle(LOCK + 6, 1);

        // R11 and all others: random traffic against the model.
        tag = "R11";
        for (int i = 0; i < 4000; i++) begin
            bit rv = ($urandom % 8) == 0;
            bit [1:0] rm = 2'($urandom % 4);
            bit wk = ($urandom % 12) == 0;
            bit fb = ($urandom % 3) == 0;
            if (($urandom % 200) == 0) fb_limit = 8'($urandom % 5);
            cyc(rv, rm, wk, fb);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule